// File: doc/BRIEF.md
# Sampling Sequencer for a Successive-Approximation Converter

This block is the digital side of a successive-approximation converter front end. It brings the converter up and down with an enable input. It launches conversions through a start/done handshake, either one at a time on request or as a continuous stream. A divisor with an integer part and a fractional part paces the stream. After each conversion the block can step the analog multiplexer selection through a programmable set of channels.

Each finished conversion is captured into a result register. A one-cycle valid pulse then presents the value, its error bit and the channel it was taken from. Two error indications are kept: one that follows the latest conversion, and one that latches until it is cleared. Bus decoding and the analog converter are outside this block. The control inputs arrive already decoded as plain signals.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `ready`, `conv_start`, `res_valid`, `err_last`, `err_sticky`, `result` and `res_chan` are all 0.
- R2: `ready` is 1 only while the block is enabled and no conversion is in flight. It is 0 in every cycle in which `conv_start` is 1.
- R3: A one-cycle pulse on `cfg_start_once` while enabled produces exactly one `conv_start` pulse. The request then clears itself. `conv_start` never stays high for two consecutive cycles.
- R4: With `cfg_start_many` held at 1 and both divisor fields 0, each new `conv_start` appears two cycles after the cycle in which `conv_done` was high.
- R5: With `cfg_start_many` held at 1 and a non-zero divisor (fields held steady), consecutive starts are spaced `cfg_div_int` or `cfg_div_int`+1 cycles apart. The extra cycle is taken whenever the running sum of `cfg_div_frac` in 8 bits carries. With int 20 and fraction 64, any 8 consecutive intervals therefore total 162 cycles.
- R6: Once `cfg_start_many` returns to 0, no further conversion is started.
- R7: For every `conv_done` accepted during a conversion, `res_valid` is 1 for exactly the next cycle. At that point `result` equals the sampled `conv_data` and `res_chan` equals the `conv_chan` the conversion was started on.
- R8: `err_last` follows `conv_err` of the latest conversion. `err_sticky` sets on any conversion with `conv_err`=1 and clears only through `err_sticky_clr`. A completion with an error in the same cycle as a clear leaves `err_sticky` at 1.
- R9: With a non-zero `cfg_rr_mask` (bit n stands for channel n), `conv_chan` moves after each conversion to the next higher channel whose mask bit is 1. When no higher channel qualifies, it moves to the lowest such channel.
- R10: A pulse on `cfg_chan_wr` loads `cfg_chan_sel` into `conv_chan`. With `cfg_rr_mask` equal to 0, the loaded channel is used for every conversion unchanged.
- R11: While `cfg_enable` is 0, `ready` is 0, no conversion starts, start requests are discarded, and a `conv_done` arriving for an aborted conversion produces no `res_valid`. When the block is re-enabled with a stream request, the first start follows a full, unextended integer period: 20 cycles for int 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Power-up / enable of the converter sequencing |
| cfg_start_once | input | 1 | Pulse requesting a single conversion |
| cfg_start_many | input | 1 | Level requesting continuous conversions |
| cfg_chan_sel | input | 4 | Channel value to load |
| cfg_chan_wr | input | 1 | Load strobe for `cfg_chan_sel` |
| cfg_rr_mask | input | 9 | Channels taking part in rotation, one bit per channel |
| cfg_div_int | input | 16 | Integer part of the pacing divisor |
| cfg_div_frac | input | 8 | Fractional part of the pacing divisor, in 1/256 |
| err_sticky_clr | input | 1 | Clears the latched error flag |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 4 | Multiplexer selection for the current conversion |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter result, valid with `conv_done` |
| conv_err | input | 1 | Converter error, valid with `conv_done` |
| ready | output | 1 | Idle and able to begin a conversion |
| result | output | 12 | Value of the latest conversion |
| err_last | output | 1 | Error bit of the latest conversion |
| err_sticky | output | 1 | Latched error indication |
| res_valid | output | 1 | One-cycle pulse for a new result |
| res_chan | output | 4 | Channel of the latest result |

## Verification
An erroneous conversion completing and a software clear of the latched error flag can land on the same clock edge. The bench provokes this by holding `err_sticky_clr` high across a whole conversion whose model returns an error. It then judges the flag in the cycle where `res_valid` appears: the set must win there, and the flag must drop only under a later clear. The channel load strobe and the rotation step could also meet, so the bench issues loads only while the block is idle. It checks the rotation order from a table of masks and start channels.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_IDLE = 2'd1,
    SQ_CONV = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_pace_div.sv
`timescale 1ns/1ps
module adc_pace_div #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);

  localparam int unsigned LIM_W = INT_W + 1;

  logic [INT_W-1:0]  cnt_q, cnt_n;
  logic [FRAC_W-1:0] acc_q, acc_n;
  logic              ext_q, ext_n;
  logic [LIM_W-1:0]  limit;
  logic [FRAC_W:0]   acc_sum;

  assign limit   = {1'b0, div_int} + {{INT_W{1'b0}}, ext_q};
  assign acc_sum = {1'b0, acc_q} + {1'b0, div_frac};
  assign tick    = run && (({1'b0, cnt_q} + {{INT_W{1'b0}}, 1'b1}) >= limit);

  always_comb begin
    cnt_n = cnt_q;
    acc_n = acc_q;
    ext_n = ext_q;
    if (!run) begin
      cnt_n = '0;
      acc_n = '0;
      ext_n = 1'b0;
    end else if (tick) begin
      cnt_n = '0;
      acc_n = acc_sum[FRAC_W-1:0];
      ext_n = acc_sum[FRAC_W];
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      acc_q <= acc_n;
      ext_q <= ext_n;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div_int > 1) |=> (!tick || div_int <= 1)); // R5

endmodule

// File: rtl/adc_chan_rotor.sv
`timescale 1ns/1ps
module adc_chan_rotor #(
  parameter int unsigned N_CH = 9,
  parameter int unsigned CH_W = 4
) (
  input  logic [CH_W-1:0] cur,
  input  logic [N_CH-1:0] mask,
  output logic            active,
  output logic [CH_W-1:0] nxt
);

  logic            hi_hit, lo_hit;
  logic [CH_W-1:0] hi_idx, lo_idx;

  assign active = |mask;

  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_idx = cur;
    lo_idx = cur;
    for (int j = N_CH - 1; j >= 0; j--) begin
      if (mask[j]) begin
        lo_hit = 1'b1;
        lo_idx = CH_W'(j);
        if (CH_W'(j) > cur) begin
          hi_hit = 1'b1;
          hi_idx = CH_W'(j);
        end
      end
    end
    if (hi_hit)      nxt = hi_idx;
    else if (lo_hit) nxt = lo_idx;
    else             nxt = cur;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned CH_W    = 4,
  parameter int unsigned N_CH    = 9,
  parameter int unsigned DINT_W  = 16,
  parameter int unsigned DFRAC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_start_once,
  input  logic               cfg_start_many,
  input  logic [CH_W-1:0]    cfg_chan_sel,
  input  logic               cfg_chan_wr,
  input  logic [N_CH-1:0]    cfg_rr_mask,
  input  logic [DINT_W-1:0]  cfg_div_int,
  input  logic [DFRAC_W-1:0] cfg_div_frac,
  input  logic               err_sticky_clr,
  output logic               conv_start,
  output logic [CH_W-1:0]    conv_chan,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  input  logic               conv_err,
  output logic               ready,
  output logic [DATA_W-1:0]  result,
  output logic               err_last,
  output logic               err_sticky,
  output logic               res_valid,
  output logic [CH_W-1:0]    res_chan
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  seq_state_e        state_q, state_n;
  logic              once_q, once_n;
  logic              tpend_q, tpend_n;
  logic              start_q, start_n;
  logic [CH_W-1:0]   chan_q, chan_n;
  logic [DATA_W-1:0] res_q, res_n;
  logic              elast_q, elast_n;
  logic              estk_q, estk_n;
  logic              vld_q, vld_n;
  logic [CH_W-1:0]   rchan_q, rchan_n;

  logic            div_zero, div_run, div_tick;
  logic            many_go, launch_go, done_ok;
  logic            rot_active;
  logic [CH_W-1:0] rot_next;

  assign div_zero = (cfg_div_int == '0) && (cfg_div_frac == '0);
  assign div_run  = cfg_enable && cfg_start_many && !div_zero;

  adc_pace_div #(.INT_W(DINT_W), .FRAC_W(DFRAC_W)) i_pace (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .run      (div_run),
    .div_int  (cfg_div_int),
    .div_frac (cfg_div_frac),
    .tick     (div_tick)
  );

  adc_chan_rotor #(.N_CH(N_CH), .CH_W(CH_W)) i_rotor (
    .cur    (chan_q),
    .mask   (cfg_rr_mask),
    .active (rot_active),
    .nxt    (rot_next)
  );

  assign many_go   = cfg_start_many && (div_zero || div_tick || tpend_q);
  assign launch_go = cfg_enable && (state_q == SQ_IDLE) && (once_q || many_go);
  assign done_ok   = cfg_enable && (state_q == SQ_CONV) && conv_done;

  always_comb begin
    state_n = state_q;
    if (!cfg_enable) begin
      state_n = SQ_OFF;
    end else begin
      unique case (state_q)
        SQ_OFF:  state_n = SQ_IDLE;
        SQ_IDLE: if (launch_go) state_n = SQ_CONV;
        SQ_CONV: if (conv_done) state_n = SQ_IDLE;
        default: state_n = SQ_OFF;
      endcase
    end
  end

  always_comb begin
    once_n  = once_q;
    tpend_n = tpend_q;
    chan_n  = chan_q;
    res_n   = res_q;
    elast_n = elast_q;
    estk_n  = estk_q;
    rchan_n = rchan_q;
    start_n = launch_go;
    vld_n   = done_ok;

    if (!cfg_enable)         once_n = 1'b0;
    else if (cfg_start_once) once_n = 1'b1;
    else if (launch_go)      once_n = 1'b0;

    if (!div_run || launch_go) tpend_n = 1'b0;
    else if (div_tick)         tpend_n = 1'b1;

    if (cfg_chan_wr)                  chan_n = cfg_chan_sel;
    else if (done_ok && rot_active)   chan_n = rot_next;

    if (done_ok) begin
      res_n   = conv_data;
      elast_n = conv_err;
      rchan_n = chan_q;
    end

    if (done_ok && conv_err) estk_n = 1'b1;
    else if (err_sticky_clr) estk_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= SQ_OFF;
      once_q  <= 1'b0;
      tpend_q <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
      res_q   <= '0;
      elast_q <= 1'b0;
      estk_q  <= 1'b0;
      vld_q   <= 1'b0;
      rchan_q <= '0;
    end else begin
      state_q <= state_n;
      once_q  <= once_n;
      tpend_q <= tpend_n;
      start_q <= start_n;
      chan_q  <= chan_n;
      if (done_ok) begin
        res_q   <= res_n;
        elast_q <= elast_n;
        rchan_q <= rchan_n;
      end
      estk_q  <= estk_n;
      vld_q   <= vld_n;
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign ready      = cfg_enable && (state_q == SQ_IDLE);
  assign result     = res_q;
  assign err_last   = elast_q;
  assign err_sticky = estk_q;
  assign res_valid  = vld_q;
  assign res_chan   = rchan_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    conv_start |=> !conv_start); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n_i)
    conv_start |-> !ready); // R2
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n_i)
    !cfg_enable |=> !conv_start); // R11
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n_i)
    res_valid |-> $past(conv_done)); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n_i)
    err_sticky && !err_sticky_clr |=> err_sticky); // R8
  AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n_i)
    res_valid && err_last |-> err_sticky); // R8

endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_start_once = 1'b0;
  logic        cfg_start_many = 1'b0;
  logic [3:0]  cfg_chan_sel = '0;
  logic        cfg_chan_wr = 1'b0;
  logic [8:0]  cfg_rr_mask = '0;
  logic [15:0] cfg_div_int = '0;
  logic [7:0]  cfg_div_frac = '0;
  logic        err_sticky_clr = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done;
  logic [11:0] conv_data;
  logic        conv_err;
  logic        ready;
  logic [11:0] result;
  logic        err_last;
  logic        err_sticky;
  logic        res_valid;
  logic [3:0]  res_chan;

  always #5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_start_once(cfg_start_once), .cfg_start_many(cfg_start_many),
    .cfg_chan_sel(cfg_chan_sel), .cfg_chan_wr(cfg_chan_wr),
    .cfg_rr_mask(cfg_rr_mask), .cfg_div_int(cfg_div_int),
    .cfg_div_frac(cfg_div_frac), .err_sticky_clr(err_sticky_clr),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .conv_err(conv_err), .ready(ready),
    .result(result), .err_last(err_last), .err_sticky(err_sticky),
    .res_valid(res_valid), .res_chan(res_chan)
  );

  // converter model: done three edges after the start is seen
  logic [11:0] model_val = '0;
  logic        model_err = 1'b0;
  int          wcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt      <= 0;
      conv_done <= 1'b0;
      conv_data <= '0;
      conv_err  <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) wcnt <= 3;
      else if (wcnt != 0) begin
        wcnt <= wcnt - 1;
        if (wcnt == 1) begin
          conv_done <= 1'b1;
          conv_data <= model_val;
          conv_err  <= model_err;
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_start = 0, n_valid = 0, last_done = 0, gap_last = 0;
  int st [0:31];
  logic [3:0] start_chan;
  always @(negedge clk) begin
    if (conv_start) begin
      st[n_start % 32] = cyc;
      start_chan = conv_chan;
      gap_last = cyc - last_done;
      n_start++;
    end
    if (conv_done) last_done = cyc;
    if (res_valid) n_valid++;
  end

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_once(output bit got);
    cfg_start_once = 1'b1;
    tick_n(1);
    cfg_start_once = 1'b0;
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      tick_n(1);
      if (res_valid) got = 1;
    end
  endtask

  // rotation table: mask, start channel, four expected result channels
  localparam logic [28:0] ROT_TBL [0:4] = '{
    {9'b000100101, 4'd2, 4'd2, 4'd5, 4'd0, 4'd2},
    {9'b000000000, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7},
    {9'b100000000, 4'd3, 4'd3, 4'd8, 4'd8, 4'd8},
    {9'b110000001, 4'd8, 4'd8, 4'd0, 4'd7, 4'd8},
    {9'b111111111, 4'd7, 4'd7, 4'd8, 4'd0, 4'd1}
  };

  initial begin
    #200000ns;
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    int s0, v0, sum, t0;
    string rq;
    tick_n(2);
    // R1 reset state
    chk(!ready && !conv_start && !res_valid, "R1", "flags in reset", ready, 0);
    chk(result == 0 && res_chan == 0 && !err_last && !err_sticky, "R1",
        "result in reset", result, 0);
    rst_n = 1'b1;
    tick_n(4);
    chk(!ready && result == 0, "R1", "after release, disabled", ready, 0);

    cfg_enable = 1'b1;
    tick_n(2);
    chk(ready == 1'b1, "R2", "ready when enabled idle", ready, 1);

    // table walk: rotation, single starts, results
    for (int e = 0; e < 5; e++) begin
      cfg_rr_mask  = ROT_TBL[e][28:20];
      cfg_chan_sel = ROT_TBL[e][19:16];
      cfg_chan_wr  = 1'b1;
      tick_n(1);
      cfg_chan_wr  = 1'b0;
      rq = (ROT_TBL[e][28:20] == 0) ? "R10" : "R9";
      for (int k = 0; k < 4; k++) begin
        logic [3:0] expc;
        expc = ROT_TBL[e][15 - 4*k -: 4];
        model_val = 12'(12'h100 * e + 16 * k + 5);
        s0 = n_start;
        do_once(got);
        chk(got, "R7", "valid pulse seen", got, 1);
        chk(result == model_val, "R7", "result value", result, model_val);
        chk(res_chan == expc, rq, "result channel", res_chan, expc);
        chk(start_chan == expc, rq, "channel at start", start_chan, expc);
        tick_n(1);
        chk(!res_valid, "R7", "valid one cycle", res_valid, 0);
        chk(n_start == s0 + 1, "R3", "one start per request", n_start - s0, 1);
        chk(ready, "R2", "ready after completion", ready, 1);
      end
    end

    // R8: error flags
    cfg_rr_mask = '0;
    model_err = 1'b1;
    do_once(got);
    chk(err_last && err_sticky, "R8", "error sets both", {err_last, err_sticky}, 3);
    model_err = 1'b0;
    do_once(got);
    chk(!err_last && err_sticky, "R8", "last clears, sticky keeps",
        {err_last, err_sticky}, 1);
    err_sticky_clr = 1'b1;
    tick_n(1);
    err_sticky_clr = 1'b0;
    chk(!err_sticky, "R8", "sticky clear", err_sticky, 0);
    // same-cycle: error completion while clear held
    model_err = 1'b1;
    err_sticky_clr = 1'b1;
    do_once(got);
    chk(err_sticky, "R8", "set wins over clear", err_sticky, 1);
    err_sticky_clr = 1'b0;
    model_err = 1'b0;
    tick_n(2);
    chk(err_sticky, "R8", "sticky held after clear released", err_sticky, 1);
    err_sticky_clr = 1'b1;
    tick_n(1);
    err_sticky_clr = 1'b0;
    chk(!err_sticky, "R8", "sticky cleared later", err_sticky, 0);

    // R4: back-to-back stream with zero divisor
    s0 = n_start;
    cfg_start_many = 1'b1;
    for (int i = 0; i < 100 && n_start < s0 + 4; i++) tick_n(1);
    chk(n_start >= s0 + 4, "R4", "stream running", n_start - s0, 4);
    chk(gap_last == 2, "R4", "done-to-start gap", gap_last, 2);
    // R6: stop the stream
    cfg_start_many = 1'b0;
    s0 = n_start;
    tick_n(30);
    chk(n_start == s0, "R6", "no start after stop", n_start - s0, 0);

    // R5: fractional pacing, int 20 + 64/256
    cfg_div_int = 16'd20;
    cfg_div_frac = 8'd64;
    tick_n(2);
    s0 = n_start;
    cfg_start_many = 1'b1;
    for (int i = 0; i < 400 && n_start < s0 + 10; i++) tick_n(1);
    sum = 0;
    for (int i = 1; i < 9; i++) begin
      int d;
      d = st[(s0 + i + 1) % 32] - st[(s0 + i) % 32];
      sum += d;
      chk(d == 20 || d == 21, "R5", "interval 20 or 21", d, 20);
    end
    chk(sum == 162, "R5", "eight intervals total", sum, 162);

    // R11: abort mid-conversion
    for (int i = 0; i < 40 && !conv_start; i++) tick_n(1);
    tick_n(1);
    cfg_enable = 1'b0;
    v0 = n_valid;
    s0 = n_start;
    chk(!ready, "R11", "ready low when disabled", ready, 0);
    tick_n(15);
    chk(n_valid == v0, "R11", "aborted done ignored", n_valid - v0, 0);
    chk(n_start == s0, "R11", "no start while disabled", n_start - s0, 0);
    cfg_div_frac = 8'd0;
    t0 = cyc;
    cfg_enable = 1'b1;
    for (int i = 0; i < 60 && n_start == s0; i++) tick_n(1);
    chk(st[s0 % 32] - t0 == 20, "R11", "divider restarted", st[s0 % 32] - t0, 20);
    cfg_start_many = 1'b0;
    tick_n(10);

    // R11: start request while disabled is discarded
    cfg_enable = 1'b0;
    tick_n(2);
    cfg_start_once = 1'b1;
    tick_n(1);
    cfg_start_once = 1'b0;
    tick_n(2);
    s0 = n_start;
    cfg_enable = 1'b1;
    tick_n(20);
    chk(n_start == s0, "R11", "request while off discarded", n_start - s0, 0);
    chk(ready, "R2", "ready after re-enable", ready, 1);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule